// File: doc/BRIEF.md
# Trap Entry Controller

This block works out every architectural state change a hart makes when it takes a trap. The core gives it, in one request cycle, the trap identity (an interrupt flag and a code), the PC of the trapping instruction, the faulting address, the current privilege level, the status register, both delegation masks and both trap vector bases. At the next clock edge the block presents the new PC, the new privilege level and the new status word. It also presents one cause/EPC/trap-value triple with a write strobe for exactly one of the two register banks, supervisor or machine.

The decision runs in three steps. First the raw request becomes a final cause value: interrupts get the top bit set, and environment calls are renamed to match the calling privilege. Next, a delegation bit picked from the interrupt mask or the exception mask decides whether the trap is handled in supervisor or machine mode. Last, the status fields of the chosen level are pushed: the interrupt enable is saved into its previous-enable bit, the current privilege is saved into the previous-privilege field, and the enable is cleared.

Top module: `trap_entry_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, both bank write strobes are low, the privilege output is machine (2'b11) and the PC output is the RESET_PC parameter (default 0).
- R2: For an interrupt request the written cause has bit 31 set and the request code in bits 30:0. For an exception bit 31 is clear.
- R3: An exception with code 8 (environment call) is written with cause 8 from user (2'b00), 9 from supervisor (2'b01) and 11 from machine (2'b11). Other codes pass through unchanged.
- R4: An interrupt looks up the interrupt delegation mask and an exception looks up the exception delegation mask. The bit index is the final cause without bit 31, and an index of 32 or above never delegates.
- R5: A trap goes to supervisor only when the current privilege is user or supervisor and the looked-up delegation bit is 1. In every other case it goes to machine.
- R6: One clock after a valid request, exactly one bank strobe is high for one cycle. That bank's cause and EPC carry the final cause and the request PC, and the PC output carries that level's vector base.
- R7: The chosen bank's trap value is the faulting address when the trap is an exception with cause 0, 1, 4, 5, 6, 7, 12, 13 or 15. Otherwise it is zero.
- R8: On supervisor entry the status output copies bit 1 into bit 5, writes privilege bit 0 into bit 8 and clears bit 1. All other bits are unchanged.
- R9: On machine entry the status output copies bit 3 into bit 7, writes the privilege into bits 12:11 and clears bit 3. All other bits are unchanged.
- R10: After a trap the privilege output is supervisor (2'b01) or machine (2'b11), matching the chosen bank.
- R11: A cycle with no valid request leaves both strobes low and holds the PC, privilege and status outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | Trap request this cycle |
| trap_is_irq | input | 1 | 1 = interrupt, 0 = exception |
| trap_code | input | 31 | Interrupt or exception code |
| trap_pc | input | 32 | PC of the trapping instruction |
| trap_addr | input | 32 | Faulting address |
| cur_priv | input | 2 | Current privilege (00 user, 01 supervisor, 11 machine) |
| cur_status | input | 32 | Current status register |
| exc_deleg | input | 32 | Exception delegation mask |
| irq_deleg | input | 32 | Interrupt delegation mask |
| s_vec_base | input | 32 | Supervisor trap vector base |
| m_vec_base | input | 32 | Machine trap vector base |
| nxt_pc | output | 32 | PC after trap entry |
| nxt_priv | output | 2 | Privilege after trap entry |
| nxt_status | output | 32 | Status after trap entry |
| s_wr | output | 1 | Supervisor bank write strobe |
| s_cause | output | 32 | Supervisor cause value |
| s_epc | output | 32 | Supervisor EPC value |
| s_tval | output | 32 | Supervisor trap value |
| m_wr | output | 1 | Machine bank write strobe |
| m_cause | output | 32 | Machine cause value |
| m_epc | output | 32 | Machine EPC value |
| m_tval | output | 32 | Machine trap value |

## Verification
The assertions assume the current privilege is never the reserved encoding 2'b10 and that all request inputs are stable in the cycle trap_valid is high. The supervisor-field checks also assume that routing to supervisor implies a privilege of user or supervisor, which is what the router guarantees. The stimulus table uses only the three legal privilege levels and changes inputs only on the falling edge. It mixes delegated and undelegated codes so that a wrong mask choice, a dropped index bit or a missing privilege gate each change the chosen bank.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;

  // status field positions decoded by the rest of the hart
  localparam int ST_SIE  = 1;
  localparam int ST_MIE  = 3;
  localparam int ST_SPIE = 5;
  localparam int ST_MPIE = 7;
  localparam int ST_SPP  = 8;
  localparam int ST_MPP  = 11;

  localparam int ECALL_CODE = 8;

  // causes that carry a faulting address in the trap-value register
  localparam int N_ADDR_CAUSES = 9;
  localparam int ADDR_CAUSES [N_ADDR_CAUSES] = '{0, 1, 4, 5, 6, 7, 12, 13, 15};

  // delegation is possible from user or supervisor only
  function automatic logic may_delegate(input logic [1:0] priv);
    return (priv == PRIV_U) || (priv == PRIV_S);
  endfunction

endpackage

// File: rtl/trap_cause_unit.sv
module trap_cause_unit
  import trap_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            is_irq,
  input  logic [XLEN-2:0] code,
  input  logic [1:0]      priv,
  output logic [XLEN-1:0] fixed_cause,
  output logic [XLEN-1:0] deleg_idx,
  output logic            has_tval
);

  logic [XLEN-1:0] code_ext;
  logic [N_ADDR_CAUSES-1:0] addr_hit;

  assign code_ext = {1'b0, code};

  // one comparator per address-carrying cause
  for (genvar g = 0; g < N_ADDR_CAUSES; g++) begin : g_addr_match
    assign addr_hit[g] = (code_ext == XLEN'(ADDR_CAUSES[g]));
  end

  always_comb begin
    deleg_idx = code_ext;
    if (!is_irq && code_ext == XLEN'(ECALL_CODE))
      deleg_idx = XLEN'(ECALL_CODE) + XLEN'(priv);
    fixed_cause = deleg_idx;
    fixed_cause[XLEN-1] = is_irq;
    has_tval = !is_irq && (|addr_hit);
  end

endmodule

// File: rtl/trap_route.sv
module trap_route
  import trap_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            is_irq,
  input  logic [XLEN-1:0] deleg_idx,
  input  logic [1:0]      priv,
  input  logic [XLEN-1:0] exc_deleg,
  input  logic [XLEN-1:0] irq_deleg,
  output logic            to_s
);

  localparam int IDX_W = $clog2(XLEN);

  logic [XLEN-1:0] mask;
  logic            in_range;
  logic            bit_set;

  always_comb begin
    mask     = is_irq ? irq_deleg : exc_deleg;
    in_range = deleg_idx < XLEN'(XLEN);
    bit_set  = in_range && mask[deleg_idx[IDX_W-1:0]];
    to_s     = may_delegate(priv) && bit_set;
  end

endmodule

// File: rtl/trap_status_update.sv
module trap_status_update
  import trap_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] status,
  input  logic [1:0]      priv,
  input  logic            to_s,
  output logic [XLEN-1:0] status_out
);

  always_comb begin
    status_out = status;
    if (to_s) begin
      status_out[ST_SPIE] = status[ST_SIE];
      status_out[ST_SPP]  = priv[0];
      status_out[ST_SIE]  = 1'b0;
    end else begin
      status_out[ST_MPIE]          = status[ST_MIE];
      status_out[ST_MPP+1:ST_MPP]  = priv;
      status_out[ST_MIE]           = 1'b0;
    end
  end

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_entry_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_valid,
  input  logic            trap_is_irq,
  input  logic [XLEN-2:0] trap_code,
  input  logic [XLEN-1:0] trap_pc,
  input  logic [XLEN-1:0] trap_addr,
  input  logic [1:0]      cur_priv,
  input  logic [XLEN-1:0] cur_status,
  input  logic [XLEN-1:0] exc_deleg,
  input  logic [XLEN-1:0] irq_deleg,
  input  logic [XLEN-1:0] s_vec_base,
  input  logic [XLEN-1:0] m_vec_base,
  output logic [XLEN-1:0] nxt_pc,
  output logic [1:0]      nxt_priv,
  output logic [XLEN-1:0] nxt_status,
  output logic            s_wr,
  output logic [XLEN-1:0] s_cause,
  output logic [XLEN-1:0] s_epc,
  output logic [XLEN-1:0] s_tval,
  output logic            m_wr,
  output logic [XLEN-1:0] m_cause,
  output logic [XLEN-1:0] m_epc,
  output logic [XLEN-1:0] m_tval
);

  // named internal events
  logic [XLEN-1:0] fixed_cause;
  logic [XLEN-1:0] deleg_idx;
  logic            has_tval;
  logic            route_to_s;
  logic [XLEN-1:0] status_upd;
  logic [XLEN-1:0] tval_val;

  trap_cause_unit #(.XLEN(XLEN)) u_cause (
    .is_irq      (trap_is_irq),
    .code        (trap_code),
    .priv        (cur_priv),
    .fixed_cause (fixed_cause),
    .deleg_idx   (deleg_idx),
    .has_tval    (has_tval)
  );

  trap_route #(.XLEN(XLEN)) u_route (
    .is_irq    (trap_is_irq),
    .deleg_idx (deleg_idx),
    .priv      (cur_priv),
    .exc_deleg (exc_deleg),
    .irq_deleg (irq_deleg),
    .to_s      (route_to_s)
  );

  trap_status_update #(.XLEN(XLEN)) u_status (
    .status     (cur_status),
    .priv       (cur_priv),
    .to_s       (route_to_s),
    .status_out (status_upd)
  );

  assign tval_val = has_tval ? trap_addr : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt_pc     <= XLEN'(RESET_PC);
      nxt_priv   <= PRIV_M;
      nxt_status <= '0;
      s_wr       <= 1'b0;
      m_wr       <= 1'b0;
      s_cause    <= '0;
      s_epc      <= '0;
      s_tval     <= '0;
      m_cause    <= '0;
      m_epc      <= '0;
      m_tval     <= '0;
    end else begin
      s_wr <= trap_valid && route_to_s;
      m_wr <= trap_valid && !route_to_s;
      if (trap_valid) begin
        nxt_status <= status_upd;
        if (route_to_s) begin
          nxt_pc   <= s_vec_base;
          nxt_priv <= PRIV_S;
          s_cause  <= fixed_cause;
          s_epc    <= trap_pc;
          s_tval   <= tval_val;
        end else begin
          nxt_pc   <= m_vec_base;
          nxt_priv <= PRIV_M;
          m_cause  <= fixed_cause;
          m_epc    <= trap_pc;
          m_tval   <= tval_val;
        end
      end
    end
  end

  // ---------------- assertions ----------------
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!s_wr && !m_wr && nxt_priv == PRIV_M));

  assert_one_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> (s_wr ^ m_wr));

  assert_bank_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({s_wr, m_wr}));

  assert_vec_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> (nxt_pc == (s_wr ? $past(s_vec_base) : $past(m_vec_base))));

  assert_epc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> ((s_wr ? s_epc : m_epc) == $past(trap_pc)));

  assert_irq_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> ((s_wr ? s_cause[XLEN-1] : m_cause[XLEN-1]) == $past(trap_is_irq)));

  assert_machine_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && cur_priv == PRIV_M) |=> m_wr);

  assert_irq_no_tval_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_is_irq) |=> ((s_wr ? s_tval : m_tval) == '0));

  assert_s_ie_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    s_wr |-> (!nxt_status[ST_SIE] && nxt_status[ST_SPIE] == $past(cur_status[ST_SIE])));

  assert_m_ie_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    m_wr |-> (!nxt_status[ST_MIE] && nxt_status[ST_MPP+1:ST_MPP] == $past(cur_priv)));

  assert_priv_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (s_wr || m_wr) |-> (nxt_priv == (s_wr ? PRIV_S : PRIV_M)));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_valid && !s_wr && !m_wr) |=> (!s_wr && !m_wr && $stable(nxt_pc) && $stable(nxt_status)));

endmodule

// File: tb/trap_entry_ctrl_tb.sv
`timescale 1ns/1ps
module trap_entry_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_valid = 1'b0;
  logic        trap_is_irq = 1'b0;
  logic [30:0] trap_code = '0;
  logic [31:0] trap_pc = '0, trap_addr = '0, cur_status = '0;
  logic [1:0]  cur_priv = 2'b11;
  logic [31:0] exc_deleg = '0, irq_deleg = '0, s_vec_base = '0, m_vec_base = '0;
  logic [31:0] nxt_pc, nxt_status, s_cause, s_epc, s_tval, m_cause, m_epc, m_tval;
  logic [1:0]  nxt_priv;
  logic        s_wr, m_wr;

  always #2 clk = ~clk;

  trap_entry_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_is_irq(trap_is_irq),
    .trap_code(trap_code), .trap_pc(trap_pc), .trap_addr(trap_addr),
    .cur_priv(cur_priv), .cur_status(cur_status), .exc_deleg(exc_deleg),
    .irq_deleg(irq_deleg), .s_vec_base(s_vec_base), .m_vec_base(m_vec_base),
    .nxt_pc(nxt_pc), .nxt_priv(nxt_priv), .nxt_status(nxt_status),
    .s_wr(s_wr), .s_cause(s_cause), .s_epc(s_epc), .s_tval(s_tval),
    .m_wr(m_wr), .m_cause(m_cause), .m_epc(m_epc), .m_tval(m_tval)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic        irq;
    logic [30:0] code;
    logic [1:0]  priv;
    logic        exp_s;
    logic [31:0] exp_cause;
    logic        exp_tval;
  } vec_t;

  // exc mask bits 1,2,8,13 ; irq mask bits 5,9
  localparam logic [31:0] EDELEG = 32'h0000_2106;
  localparam logic [31:0] IDELEG = 32'h0000_0220;
  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 31'd13, 2'b00, 1'b1, 32'd13,        1'b1}, // R4 R5 R7 delegated page fault
    '{1'b0, 31'd13, 2'b11, 1'b0, 32'd13,        1'b1}, // R5 machine never delegates
    '{1'b0, 31'd5,  2'b01, 1'b0, 32'd5,         1'b1}, // R4 undelegated
    '{1'b0, 31'd2,  2'b01, 1'b1, 32'd2,         1'b0}, // R7 no address
    '{1'b0, 31'd8,  2'b00, 1'b1, 32'd8,         1'b0}, // R3 user call
    '{1'b0, 31'd8,  2'b01, 1'b0, 32'd9,         1'b0}, // R3 supervisor call
    '{1'b0, 31'd8,  2'b11, 1'b0, 32'd11,        1'b0}, // R3 machine call
    '{1'b1, 31'd5,  2'b01, 1'b1, 32'h8000_0005, 1'b0}, // R2 R4 delegated irq
    '{1'b1, 31'd5,  2'b11, 1'b0, 32'h8000_0005, 1'b0}, // R5
    '{1'b1, 31'd7,  2'b00, 1'b0, 32'h8000_0007, 1'b0}, // R4
    '{1'b1, 31'd9,  2'b00, 1'b1, 32'h8000_0009, 1'b0}, // R2
    '{1'b0, 31'd1,  2'b00, 1'b1, 32'd1,         1'b1}, // R7
    '{1'b1, 31'd13, 2'b00, 1'b0, 32'h8000_000D, 1'b0}, // R4 irq ignores exc mask
    '{1'b0, 31'd15, 2'b01, 1'b0, 32'd15,        1'b1}, // R7
    '{1'b0, 31'd3,  2'b00, 1'b0, 32'd3,         1'b0}, // R7 breakpoint no address
    '{1'b0, 31'd40, 2'b00, 1'b0, 32'd40,        1'b0}  // R4 index out of range
  };

  function automatic logic [31:0] exp_status(input logic [31:0] st,
                                             input logic [1:0] pv, input logic to_s);
    if (to_s)
      return (st & ~32'h0000_0122) | ({31'b0, st[1]} << 5) | ({31'b0, pv[0]} << 8);
    return (st & ~32'h0000_1888) | ({31'b0, st[3]} << 7) | ({30'b0, pv} << 11);
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] hold_pc, hold_st;
    logic [31:0] pc_e, addr_e, st_e, svec_e, mvec_e;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "s_wr", {31'b0, s_wr}, 32'd0);
    chk("R1", "m_wr", {31'b0, m_wr}, 32'd0);
    chk("R1", "priv", {30'b0, nxt_priv}, 32'd3);
    chk("R1", "pc",   nxt_pc, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle after reset strobes", {30'b0, s_wr, m_wr}, 32'd0);

    exc_deleg = EDELEG;
    irq_deleg = IDELEG;
    for (int i = 0; i < NV; i++) begin
      pc_e   = 32'h8000_0000 + 32'(i) * 32'h10;
      addr_e = 32'hDEAD_0000 | 32'(i);
      st_e   = 32'hA5A5_0000 ^ (32'(i) * 32'h1357_9BDF);
      svec_e = 32'h0000_4000 + 32'(i) * 32'h100;
      mvec_e = 32'h0000_8000 + 32'(i) * 32'h100;
      @(negedge clk);
      trap_valid  = 1'b1;
      trap_is_irq = VECS[i].irq;
      trap_code   = VECS[i].code;
      cur_priv    = VECS[i].priv;
      trap_pc     = pc_e;
      trap_addr   = addr_e;
      cur_status  = st_e;
      s_vec_base  = svec_e;
      m_vec_base  = mvec_e;
      @(negedge clk);
      trap_valid = 1'b0;
      chk("R5", "s_wr", {31'b0, s_wr}, {31'b0, VECS[i].exp_s});
      chk("R6", "m_wr", {31'b0, m_wr}, {31'b0, !VECS[i].exp_s});
      chk("R6", "pc", nxt_pc, VECS[i].exp_s ? svec_e : mvec_e);
      chk("R10", "priv", {30'b0, nxt_priv}, VECS[i].exp_s ? 32'd1 : 32'd3);
      if (VECS[i].exp_s) begin
        chk("R2_R3", "s_cause", s_cause, VECS[i].exp_cause);
        chk("R6", "s_epc", s_epc, pc_e);
        chk("R7", "s_tval", s_tval, VECS[i].exp_tval ? addr_e : 32'd0);
        chk("R8", "status", nxt_status, exp_status(st_e, VECS[i].priv, 1'b1));
      end else begin
        chk("R2_R3", "m_cause", m_cause, VECS[i].exp_cause);
        chk("R6", "m_epc", m_epc, pc_e);
        chk("R7", "m_tval", m_tval, VECS[i].exp_tval ? addr_e : 32'd0);
        chk("R9", "status", nxt_status, exp_status(st_e, VECS[i].priv, 1'b0));
      end
      @(negedge clk);
      chk("R6", "strobe one cycle", {30'b0, s_wr, m_wr}, 32'd0);
    end

    // R11: idle cycles with changed inputs leave outputs held
    hold_pc = nxt_pc;
    hold_st = nxt_status;
    s_vec_base = 32'h1111_0000;
    m_vec_base = 32'h2222_0000;
    cur_status = 32'hFFFF_FFFF;
    repeat (2) @(negedge clk);
    chk("R11", "strobes", {30'b0, s_wr, m_wr}, 32'd0);
    chk("R11", "pc held", nxt_pc, hold_pc);
    chk("R11", "status held", nxt_status, hold_st);

    // R8 with all status bits set, from user, delegated exception
    trap_valid = 1'b1; trap_is_irq = 1'b0; trap_code = 31'd2; cur_priv = 2'b00;
    @(negedge clk);
    trap_valid = 1'b0;
    chk("R8", "all-ones status", nxt_status, 32'hFFFF_FEFD);

    // R1 reset mid-run returns to reset state
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "priv after reset", {30'b0, nxt_priv}, 32'd3);
    chk("R1", "pc after reset", nxt_pc, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    summary();
    $finish;
  end

endmodule